// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This block is a small execution unit for bit-level operations on a 16-bit or 32-bit operand. The width is chosen for each request. It handles two groups of work.

The first group is single-bit tests. A test reads one addressed bit and returns it as a carry flag. It can also return the operand with that bit cleared, set or inverted. The second group is bit scans. A scan finds the lowest set bit (forward) or the highest set bit (reverse) and returns its index. The zero flag reports an operand with no bit set.

The caller presents a request for one cycle. All outputs are registered, and they appear with a valid strobe on the following cycle. The flag, index and result registers each keep their value until an operation that owns them updates them. This lets a scan of an empty operand leave the previous index in place.

Top module: `bts_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to zero, and this includes `res_valid`, `carry`, `zero`, `scan_idx` and `res_value`.
- R2: `res_valid` is high in exactly those cycles that follow a clock edge at which `req_valid` was high.
- R3: Op code 3'b000 (test) loads `carry` with the addressed bit of the operand and loads `res_value` with the width-masked operand, unchanged.
- R4: Op codes 3'b001 (clear), 3'b010 (set) and 3'b011 (invert) load `carry` with the old value of the addressed bit. They load `res_value` with the width-masked operand after that one bit is forced to 0, forced to 1 or inverted, in that order of codes.
- R5: The bit address is `bit_ofs` modulo the operand width. At 16 bits only `bit_ofs[3:0]` is used; at 32 bits all five bits are used.
- R6: `wide`=1 selects 32 bits and `wide`=0 selects 16 bits. At 16 bits, `operand[31:16]` has no effect on any output, and `res_value[31:16]` is loaded with zero.
- R7: Op code 3'b100 (forward scan) of a nonzero operand loads `scan_idx` with the index of the lowest set bit and clears `zero`.
- R8: Op code 3'b101 (reverse scan) of a nonzero operand loads `scan_idx` with the index of the highest set bit within the selected width and clears `zero`.
- R9: A scan of an operand whose bits are all zero within the selected width sets `zero` and leaves `scan_idx` at its previous value.
- R10: Test ops (R3, R4) leave `zero` and `scan_idx` unchanged. Scan ops leave `carry` and `res_value` unchanged.
- R11: Op codes 3'b110 and 3'b111 raise `res_valid` but change no other output.
- R12: A cycle with `req_valid` low changes no output other than `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| op | input | 3 | Operation code (see R3, R4, R7, R8, R11) |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| operand | input | 32 | Source operand; upper half ignored at 16 bits |
| bit_ofs | input | 5 | Bit address for test ops, taken modulo the width |
| res_valid | output | 1 | Registered results updated this cycle |
| res_value | output | 32 | Operand after test or modify |
| scan_idx | output | 5 | Index found by the last successful scan |
| carry | output | 1 | Old value of the last tested bit |
| zero | output | 1 | Set when the last scan found no bit set |

## Verification
The assertions assume two things about the inputs. First, `op`, `wide`, `operand` and `bit_ofs` are known, stable values whenever `req_valid` is high. Second, the undefined op codes carry no meaning beyond a valid strobe. The bench drives every input at the falling edge and holds it for a full cycle. It sets `req_valid` only with fully defined fields, and it uses codes 3'b110 and 3'b111 only in the scenario that checks that they have no effect. Operands with garbage in the upper half are used only at 16 bits, where that half is specified as ignored.

// File: rtl/bts_pkg.sv
package bts_pkg;

    parameter int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_TEST  = 3'b000,
        OP_CLR   = 3'b001,
        OP_SET   = 3'b010,
        OP_INV   = 3'b011,
        OP_FWD   = 3'b100,
        OP_REV   = 3'b101,
        OP_RSV6  = 3'b110,
        OP_RSV7  = 3'b111
    } bts_op_e;

    typedef struct packed {
        logic              old_bit;
        logic [DATA_W-1:0] value;
    } bit_res_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } scan_res_t;

    function automatic logic op_is_test(bts_op_e o);
        return (o == OP_TEST) || (o == OP_CLR) || (o == OP_SET) || (o == OP_INV);
    endfunction

    function automatic logic op_is_scan(bts_op_e o);
        return (o == OP_FWD) || (o == OP_REV);
    endfunction

endpackage

// File: rtl/bts_bitop.sv
module bts_bitop
    import bts_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  ofs,
    input  logic              wide,
    input  bts_op_e           op,
    output bit_res_t          res
);
    logic [IDX_W-1:0]  pos;
    logic [DATA_W-1:0] sel;

    // Offset wraps at the selected width
    assign pos = wide ? ofs : {1'b0, ofs[IDX_W-2:0]};
    assign sel = DATA_W'(1) << pos;

    always_comb begin
        res.old_bit = |(opnd & sel);
        unique case (op)
            OP_CLR:  res.value = opnd & ~sel;
            OP_SET:  res.value = opnd | sel;
            OP_INV:  res.value = opnd ^ sel;
            default: res.value = opnd;
        endcase
    end

    always_comb begin
        p_single_bit_change_r4: assert ($countones(res.value ^ opnd) <= 1)
            else $error("bitop touched more than one bit");
    end

endmodule

// File: rtl/bts_scan_tree.sv
module bts_scan_tree #(
    parameter int W = 32
) (
    input  logic [W-1:0]         bits,
    output logic                 found,
    output logic [$clog2(W)-1:0] idx
);
    localparam int LVL = $clog2(W);

    logic [W-1:0]   v_lvl [LVL+1];
    logic [LVL-1:0] i_lvl [LVL+1][W];

    // Log-depth tree: the lower half wins at every node
    always_comb begin
        v_lvl[0] = bits;
        for (int n = 0; n < W; n++) i_lvl[0][n] = '0;
        for (int l = 0; l < LVL; l++) begin
            for (int n = 0; n < W; n++) begin
                if (n < (W >> (l + 1))) begin
                    v_lvl[l+1][n] = v_lvl[l][2*n] | v_lvl[l][2*n+1];
                    i_lvl[l+1][n] = v_lvl[l][2*n] ? i_lvl[l][2*n]
                                                  : (i_lvl[l][2*n+1] | (LVL'(1) << l));
                end else begin
                    v_lvl[l+1][n] = 1'b0;
                    i_lvl[l+1][n] = '0;
                end
            end
        end
    end

    assign found = v_lvl[LVL][0];
    assign idx   = i_lvl[LVL][0];

    always_comb begin
        if (found) begin
            p_idx_hits_set_r7: assert (bits[idx])
                else $error("scan index points at a clear bit");
        end
    end

endmodule

// File: rtl/bts_scan.sv
module bts_scan
    import bts_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    input  logic              wide,
    input  logic              reverse,
    output scan_res_t         res
);
    logic [DATA_W-1:0] rev_bits;
    logic [DATA_W-1:0] tree_in;
    logic              tree_found;
    logic [IDX_W-1:0]  tree_idx;
    logic [IDX_W-1:0]  top_idx;

    // Mirror the operand within the chosen width so one tree serves both directions
    for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
        if (i < HALF_W) begin : g_low
            assign rev_bits[i] = wide ? opnd[DATA_W-1-i] : opnd[HALF_W-1-i];
        end else begin : g_high
            assign rev_bits[i] = wide ? opnd[DATA_W-1-i] : 1'b0;
        end
    end

    assign tree_in = reverse ? rev_bits : opnd;
    assign top_idx = wide ? IDX_W'(DATA_W - 1) : IDX_W'(HALF_W - 1);

    bts_scan_tree #(.W(DATA_W)) i_tree (
        .bits  (tree_in),
        .found (tree_found),
        .idx   (tree_idx)
    );

    assign res.found = tree_found;
    assign res.idx   = reverse ? (top_idx - tree_idx) : tree_idx;

endmodule

// File: rtl/bts_unit.sv
module bts_unit
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic [31:0]       operand,
    input  logic [4:0]        bit_ofs,
    output logic              res_valid,
    output logic [31:0]       res_value,
    output logic [4:0]        scan_idx,
    output logic              carry,
    output logic              zero
);
    bts_op_e           op_q;
    logic [DATA_W-1:0] opnd_m;
    bit_res_t          bit_r;
    scan_res_t         scan_r;

    assign op_q   = bts_op_e'(op);
    assign opnd_m = wide ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};

    bts_bitop i_bitop (
        .opnd (opnd_m),
        .ofs  (bit_ofs),
        .wide (wide),
        .op   (op_q),
        .res  (bit_r)
    );

    bts_scan i_scan (
        .opnd    (opnd_m),
        .wide    (wide),
        .reverse (op_q == OP_REV),
        .res     (scan_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_value <= '0;
            scan_idx  <= '0;
            carry     <= 1'b0;
            zero      <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                if (op_is_test(op_q)) begin
                    carry     <= bit_r.old_bit;
                    res_value <= bit_r.value;
                end
                if (op_is_scan(op_q)) begin
                    zero <= ~scan_r.found;
                    if (scan_r.found) scan_idx <= scan_r.idx;
                end
            end
        end
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    p_carry_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_is_test(op_q)) |=>
        carry == $past(((opnd_m >> (wide ? bit_ofs : {1'b0, bit_ofs[3:0]})) & 32'd1) != 32'd0));
    p_zero_holds_idx_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_is_scan(op_q) && opnd_m == '0) |=> (zero && $stable(scan_idx)));
    p_test_keeps_scan_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_is_test(op_q)) |=> ($stable(zero) && $stable(scan_idx)));
    p_scan_keeps_test_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_is_scan(op_q)) |=> ($stable(carry) && $stable(res_value)));

endmodule

// File: tb/test_bts_unit.sv
module test_bts_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  op;
    logic        wide;
    logic [31:0] operand;
    logic [4:0]  bit_ofs;
    logic        res_valid;
    logic [31:0] res_value;
    logic [4:0]  scan_idx;
    logic        carry;
    logic        zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] e_res;
    logic [4:0]  e_idx;
    logic        e_cf;
    logic        e_zf;

    always #5 clk = ~clk;

    bts_unit i_bts_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op(op), .wide(wide),
        .operand(operand), .bit_ofs(bit_ofs), .res_valid(res_valid),
        .res_value(res_value), .scan_idx(scan_idx), .carry(carry), .zero(zero)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check({req, " res_value"}, res_value, e_res);
        check({req, " scan_idx"}, {27'd0, scan_idx}, {27'd0, e_idx});
        check({req, " carry"}, {31'd0, carry}, {31'd0, e_cf});
        check({req, " zero"}, {31'd0, zero}, {31'd0, e_zf});
    endtask

    // Reference model written from the requirement text
    task automatic model(logic [2:0] o, logic w, logic [31:0] x, logic [4:0] b);
        logic [31:0] m;
        int          p;
        m = w ? x : {16'd0, x[15:0]};
        p = w ? int'(b) : int'(b) % 16;
        case (o)
            3'b000: begin e_cf = m[p]; e_res = m; end
            3'b001: begin e_cf = m[p]; e_res = m; e_res[p] = 1'b0; end
            3'b010: begin e_cf = m[p]; e_res = m; e_res[p] = 1'b1; end
            3'b011: begin e_cf = m[p]; e_res = m; e_res[p] = ~m[p]; end
            3'b100: begin
                e_zf = (m == 0);
                for (int i = 31; i >= 0; i--) if (m[i]) e_idx = 5'(i);
            end
            3'b101: begin
                e_zf = (m == 0);
                for (int i = 0; i < 32; i++) if (m[i]) e_idx = 5'(i);
            end
            default: ;
        endcase
    endtask

    task automatic run(string req, logic [2:0] o, logic w, logic [31:0] x, logic [4:0] b);
        @(negedge clk);
        req_valid = 1'b1; op = o; wide = w; operand = x; bit_ofs = b;
        model(o, w, x, b);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " res_valid"}, {31'd0, res_valid}, 32'd1);
        check_all(req);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; op = 3'b000; wide = 1'b1; operand = '0; bit_ofs = '0;
        repeat (3) @(negedge clk);
        e_res = '0; e_idx = '0; e_cf = 1'b0; e_zf = 1'b0;
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check_all("R1");
        rst = 1'b0;
    endtask

    task automatic t_test();
        run("R3", 3'b000, 1'b1, 32'h8000_0001, 5'd0);
        run("R3", 3'b000, 1'b1, 32'h8000_0001, 5'd31);
        run("R3", 3'b000, 1'b1, 32'h8000_0001, 5'd5);
    endtask

    task automatic t_modify();
        run("R4 clear", 3'b001, 1'b1, 32'hFFFF_FFFF, 5'd17);
        run("R4 set", 3'b010, 1'b1, 32'h0000_0000, 5'd30);
        run("R4 invert", 3'b011, 1'b1, 32'h1234_5678, 5'd3);
        run("R4 set already", 3'b010, 1'b1, 32'h0000_0010, 5'd4);
    endtask

    task automatic t_wrap();
        run("R5 16-bit wrap", 3'b010, 1'b0, 32'h0000_0000, 5'd19);
        run("R5 16-bit wrap test", 3'b000, 1'b0, 32'h0000_8000, 5'd31);
        run("R5 32-bit full", 3'b011, 1'b1, 32'h0000_0000, 5'd19);
    endtask

    task automatic t_width();
        run("R6 upper ignored", 3'b000, 1'b0, 32'hABCD_0000, 5'd0);
        run("R6 upper zeroed", 3'b011, 1'b0, 32'hFFFF_00F0, 5'd0);
    endtask

    task automatic t_fwd();
        run("R7", 3'b100, 1'b1, 32'h0010_0100, 5'd0);
        run("R7 bit31", 3'b100, 1'b1, 32'h8000_0000, 5'd0);
        run("R7 bit0", 3'b100, 1'b0, 32'hFFFF_FFFF, 5'd0);
    endtask

    task automatic t_rev();
        run("R8", 3'b101, 1'b1, 32'h0010_0100, 5'd0);
        run("R8 32-bit top", 3'b101, 1'b1, 32'hC000_0001, 5'd0);
        run("R8 16-bit top", 3'b101, 1'b0, 32'hFFFF_4001, 5'd0);
    endtask

    task automatic t_zero();
        run("R9 seed", 3'b100, 1'b1, 32'h0000_0200, 5'd0);
        run("R9 fwd empty", 3'b100, 1'b1, 32'h0000_0000, 5'd0);
        run("R9 rev empty 16", 3'b101, 1'b0, 32'hFFFF_0000, 5'd0);
    endtask

    task automatic t_isolation();
        run("R10 scan sets idx", 3'b101, 1'b1, 32'h0004_0000, 5'd0);
        run("R10 test keeps scan", 3'b011, 1'b1, 32'h0000_0000, 5'd7);
        run("R10 scan keeps test", 3'b100, 1'b1, 32'h0000_0008, 5'd1);
    endtask

    task automatic t_reserved();
        run("R11 code6", 3'b110, 1'b1, 32'hFFFF_FFFF, 5'd2);
        run("R11 code7", 3'b111, 1'b1, 32'h0000_0000, 5'd9);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0; op = 3'b011; wide = 1'b1; operand = 32'hFFFF_FFFF; bit_ofs = 5'd1;
        @(negedge clk);
        check("R12 res_valid", {31'd0, res_valid}, 32'd0);
        check_all("R12");
        check("R2 valid low", {31'd0, res_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_test();
        t_modify();
        t_wrap();
        t_width();
        t_fwd();
        t_rev();
        t_zero();
        t_isolation();
        t_reserved();
        t_idle();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule